// File: doc/BRIEF.md
# Instruction Queue with Class-Routed Dispatch

This block sits between an instruction fetch stage and three issue queues that each serve one instruction class: integer, floating point and vector. Every cycle, fetch may present a group of up to four instructions. Each instruction carries a two-bit class tag and an opaque payload. The block stores as many of them as it has room for and keeps them in program order in a twelve-entry buffer. It then dispatches from the oldest end of the buffer toward the issue queues.

Dispatch looks only at the three oldest entries and moves at most three instructions per cycle. Each destination has a per-cycle width: one for floating point, two for vector and three for integer. Each destination also reports how many free slots it has, and the usable width is the smaller of that credit and the fixed width. Every instruction that dispatches also takes one slot in a downstream completion tracker, whose free-slot count arrives as a credit. This holds for instructions of the "none" class, which need no issue slot. Dispatch is strictly in order, so the first instruction that cannot go holds back every younger one.

After dispatch, the remaining entries close up toward the oldest position. A flush input empties the buffer in a single cycle.

Top module: `iq_dispatch`

## Requirements
- R1: After synchronous reset, `fe_free` equals 12, and all issue valids and `cq_alloc` are 0.
- R2: `fe_free` reports 12 minus the current occupancy. In a non-flush cycle, the number of fetched instructions stored is min(`fe_cnt`, `fe_free`), and the excess is dropped. While `fe_free` is 0, the buffer stores nothing.
- R3: Only the three oldest entries can dispatch, and no more than three instructions dispatch in one cycle, even when more entries of a class are waiting.
- R4: Class tags are 2'b00 integer, 2'b01 floating point, 2'b10 vector and 2'b11 none. The block dispatches per cycle at most min(1, `fp_credit`) floating-point, min(2, `vec_credit`) vector and min(3, `int_credit`) integer instructions. Valids are packed from lane 0, and the results appear in the cycle after the decision.
- R5: The block dispatches no more instructions than `cq_free` in a cycle, and none-class instructions count toward that limit. `cq_alloc` gives the total dispatched, including none-class instructions.
- R6: When the oldest undispatched instruction among the three eligible entries is blocked, no younger instruction dispatches in that cycle.
- R7: Within each issue port, lane 0 carries the oldest instruction. Across cycles, instructions leave in the order fetch supplied them, because the remaining entries shift toward the oldest slot.
- R8: A flush empties the buffer in one cycle. It discards the fetch group of that cycle and dispatches nothing in that cycle, so the next cycle shows `fe_free` = 12 and `cq_alloc` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the buffer; cancel dispatch and fetch this cycle |
| fe_cnt | input | 3 | Number of valid fetched instructions (0..4) |
| fe_cls | input | 8 | Class tags, 2 bits per fetch lane, lane 0 oldest in bits [1:0] |
| fe_data | input | 64 | Payloads, 16 bits per fetch lane |
| fe_free | output | 4 | Free buffer entries; fetch ready indication |
| fp_credit | input | 4 | Free slots in the floating-point issue queue |
| vec_credit | input | 4 | Free slots in the vector issue queue |
| int_credit | input | 4 | Free slots in the integer issue queue |
| cq_free | input | 5 | Free slots in the completion tracker |
| fp_valid | output | 1 | Floating-point dispatch valid |
| fp_data | output | 16 | Floating-point dispatch payload |
| vec_valid | output | 2 | Vector dispatch valids, lane 0 oldest |
| vec_data | output | 32 | Vector dispatch payloads |
| int_valid | output | 3 | Integer dispatch valids, lane 0 oldest |
| int_data | output | 48 | Integer dispatch payloads |
| cq_alloc | output | 2 | Instructions dispatched, completion slots taken |

## Verification
Fetch writes and dispatch drains act on the buffer in the same cycle. Fetch room is sized from the occupancy before dispatch, so the bench drives full-buffer cycles in which dispatch frees entries while fetch still offers four instructions. It then checks that only the previously free count was stored and that the order of survivors is intact. Flush also collides with fetch and dispatch: flush cycles are raised with fetch groups and open credits present. The bench judges the outcome by the next cycle's free count, by quiet dispatch outputs, and by a reference queue that resumes from empty.

// File: rtl/iqd_pkg.sv
package iqd_pkg;
  typedef enum logic [1:0] {
    CL_INT  = 2'd0,
    CL_FP   = 2'd1,
    CL_VEC  = 2'd2,
    CL_NONE = 2'd3
  } iq_class_e;
endpackage

// File: rtl/iqd_buffer.sv
module iqd_buffer #(
  parameter int DW      = 16,
  parameter int DEPTH   = 12,
  parameter int FETCH_W = 4,
  parameter int DISP_W  = 3
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               flush,
  input  logic [$clog2(FETCH_W+1)-1:0]       fe_cnt,
  input  logic [2*FETCH_W-1:0]               fe_cls,
  input  logic [DW*FETCH_W-1:0]              fe_data,
  input  logic [$clog2(DISP_W+1)-1:0]        n_disp,
  output logic [$clog2(DEPTH+1)-1:0]         occ,
  output logic [2*DISP_W-1:0]                head_cls,
  output logic [DW*DISP_W-1:0]               head_data
);
  localparam int OCW = $clog2(DEPTH + 1);
  localparam int IW  = $clog2(DEPTH);

  logic [1:0]    ent_cls [DEPTH];
  logic [DW-1:0] ent_dat [DEPTH];
  logic [1:0]    nxt_cls [DEPTH];
  logic [DW-1:0] nxt_dat [DEPTH];
  logic [OCW-1:0] cnt, cnt_nxt;

  always_comb begin
    int keep, room, acc, src, j;
    room = DEPTH - int'(cnt);
    acc  = (int'(fe_cnt) < room) ? int'(fe_cnt) : room;
    keep = int'(cnt) - int'(n_disp);
    for (int i = 0; i < DEPTH; i++) begin
      nxt_cls[i] = ent_cls[i];
      nxt_dat[i] = ent_dat[i];
      src = i + int'(n_disp);
      j   = i - keep;
      if (i < keep) begin
        if (src < DEPTH) begin
          nxt_cls[i] = ent_cls[src[IW-1:0]];
          nxt_dat[i] = ent_dat[src[IW-1:0]];
        end
      end else if (j < acc) begin
        nxt_cls[i] = fe_cls[2*j +: 2];
        nxt_dat[i] = fe_data[DW*j +: DW];
      end
    end
    cnt_nxt = OCW'(keep + acc);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_nxt;
    end
    for (int i = 0; i < DEPTH; i++) begin
      ent_cls[i] <= nxt_cls[i];
      ent_dat[i] <= nxt_dat[i];
    end
  end

  genvar k;
  generate
    for (k = 0; k < DISP_W; k++) begin : g_head
      assign head_cls[2*k +: 2]   = ent_cls[k];
      assign head_data[DW*k +: DW] = ent_dat[k];
    end
  endgenerate

  assign occ = cnt;

  // R2: occupancy stays within the buffer depth
  p_occ_bound_r2: assert property (@(posedge clk) disable iff (rst)
    int'(occ) <= DEPTH);

  // R2: occupancy grows by no more than the fetch group offered
  p_grow_limit_r2: assert property (@(posedge clk) disable iff (rst)
    !flush |=> int'(occ) <= int'($past(occ)) + int'($past(fe_cnt)));

  // R8: flush leaves the buffer empty on the next cycle
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> occ == '0);
endmodule

// File: rtl/iqd_select.sv
module iqd_select
  import iqd_pkg::*;
#(
  parameter int DEPTH   = 12,
  parameter int DISP_W  = 3,
  parameter int FP_MAX  = 1,
  parameter int VEC_MAX = 2,
  parameter int INT_MAX = 3,
  parameter int CRW     = 4,
  parameter int CQW     = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic [$clog2(DEPTH+1)-1:0]   occ,
  input  logic [2*DISP_W-1:0]          head_cls,
  input  logic [CRW-1:0]               fp_credit,
  input  logic [CRW-1:0]               vec_credit,
  input  logic [CRW-1:0]               int_credit,
  input  logic [CQW-1:0]               cq_free,
  output logic [DISP_W-1:0]            go,
  output logic [$clog2(DISP_W+1)-1:0]  n_disp
);
  localparam int DCW = $clog2(DISP_W + 1);

  always_comb begin
    int used, nfp, nvec, nint, lfp, lvec, lint;
    logic stop, ok;
    iq_class_e c;
    lfp  = (int'(fp_credit)  < FP_MAX)  ? int'(fp_credit)  : FP_MAX;
    lvec = (int'(vec_credit) < VEC_MAX) ? int'(vec_credit) : VEC_MAX;
    lint = (int'(int_credit) < INT_MAX) ? int'(int_credit) : INT_MAX;
    used = 0; nfp = 0; nvec = 0; nint = 0;
    stop = flush;
    go   = '0;
    for (int k = 0; k < DISP_W; k++) begin
      c  = iq_class_e'(head_cls[2*k +: 2]);
      ok = 1'b0;
      if (!stop && k < int'(occ) && used < int'(cq_free)) begin
        case (c)
          CL_FP:   ok = (nfp  < lfp);
          CL_VEC:  ok = (nvec < lvec);
          CL_INT:  ok = (nint < lint);
          default: ok = 1'b1;
        endcase
      end
      if (ok) begin
        go[k] = 1'b1;
        used  = used + 1;
        case (c)
          CL_FP:   nfp  = nfp + 1;
          CL_VEC:  nvec = nvec + 1;
          CL_INT:  nint = nint + 1;
          default: ;
        endcase
      end else begin
        stop = 1'b1;
      end
    end
    n_disp = DCW'(used);
  end

  // R6: dispatched lanes always form an unbroken run from the oldest slot
  p_in_order_r6: assert property (@(posedge clk) disable iff (rst)
    (go & (go + 1'b1)) == '0);

  // R3: never dispatch past the occupied entries
  p_window_r3: assert property (@(posedge clk) disable iff (rst)
    int'(n_disp) <= int'(occ));

  // R5: completion credit bounds the dispatch count
  p_cq_bound_r5: assert property (@(posedge clk) disable iff (rst)
    int'(n_disp) <= int'(cq_free));
endmodule

// File: rtl/iqd_route.sv
module iqd_route
  import iqd_pkg::*;
#(
  parameter int DW      = 16,
  parameter int DISP_W  = 3,
  parameter int FP_MAX  = 1,
  parameter int VEC_MAX = 2,
  parameter int INT_MAX = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [DISP_W-1:0]            go,
  input  logic [2*DISP_W-1:0]          head_cls,
  input  logic [DW*DISP_W-1:0]         head_data,
  input  logic [$clog2(DISP_W+1)-1:0]  n_disp,
  output logic [FP_MAX-1:0]            fp_valid,
  output logic [DW*FP_MAX-1:0]         fp_data,
  output logic [VEC_MAX-1:0]           vec_valid,
  output logic [DW*VEC_MAX-1:0]        vec_data,
  output logic [INT_MAX-1:0]           int_valid,
  output logic [DW*INT_MAX-1:0]        int_data,
  output logic [$clog2(DISP_W+1)-1:0]  cq_alloc
);
  logic [FP_MAX-1:0]     fpv_c;
  logic [DW*FP_MAX-1:0]  fpd_c;
  logic [VEC_MAX-1:0]    vcv_c;
  logic [DW*VEC_MAX-1:0] vcd_c;
  logic [INT_MAX-1:0]    inv_c;
  logic [DW*INT_MAX-1:0] ind_c;

  always_comb begin
    int nf, nv, ni;
    nf = 0; nv = 0; ni = 0;
    fpv_c = '0; fpd_c = '0; vcv_c = '0; vcd_c = '0; inv_c = '0; ind_c = '0;
    for (int k = 0; k < DISP_W; k++) begin
      if (go[k]) begin
        case (iq_class_e'(head_cls[2*k +: 2]))
          CL_FP: if (nf < FP_MAX) begin
            fpv_c[nf] = 1'b1;
            fpd_c[DW*nf +: DW] = head_data[DW*k +: DW];
            nf = nf + 1;
          end
          CL_VEC: if (nv < VEC_MAX) begin
            vcv_c[nv] = 1'b1;
            vcd_c[DW*nv +: DW] = head_data[DW*k +: DW];
            nv = nv + 1;
          end
          CL_INT: if (ni < INT_MAX) begin
            inv_c[ni] = 1'b1;
            ind_c[DW*ni +: DW] = head_data[DW*k +: DW];
            ni = ni + 1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fp_valid  <= '0; fp_data  <= '0;
      vec_valid <= '0; vec_data <= '0;
      int_valid <= '0; int_data <= '0;
      cq_alloc  <= '0;
    end else begin
      fp_valid  <= fpv_c; fp_data  <= fpd_c;
      vec_valid <= vcv_c; vec_data <= vcd_c;
      int_valid <= inv_c; int_data <= ind_c;
      cq_alloc  <= n_disp;
    end
  end

  // R4: vector and integer valids are packed from lane 0
  p_vec_pack_r4: assert property (@(posedge clk) disable iff (rst)
    (vec_valid & (vec_valid + 1'b1)) == '0);
  p_int_pack_r4: assert property (@(posedge clk) disable iff (rst)
    (int_valid & (int_valid + 1'b1)) == '0);

  // R5: completion slots taken cover every routed instruction
  p_alloc_cover_r5: assert property (@(posedge clk) disable iff (rst)
    int'(cq_alloc) >= $countones(fp_valid) + $countones(vec_valid) + $countones(int_valid));
endmodule

// File: rtl/iq_dispatch.sv
module iq_dispatch #(
  parameter int DW      = 16,
  parameter int DEPTH   = 12,
  parameter int FETCH_W = 4,
  parameter int DISP_W  = 3,
  parameter int FP_MAX  = 1,
  parameter int VEC_MAX = 2,
  parameter int INT_MAX = 3,
  parameter int CRW     = 4,
  parameter int CQW     = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          flush,
  input  logic [$clog2(FETCH_W+1)-1:0]  fe_cnt,
  input  logic [2*FETCH_W-1:0]          fe_cls,
  input  logic [DW*FETCH_W-1:0]         fe_data,
  output logic [$clog2(DEPTH+1)-1:0]    fe_free,
  input  logic [CRW-1:0]                fp_credit,
  input  logic [CRW-1:0]                vec_credit,
  input  logic [CRW-1:0]                int_credit,
  input  logic [CQW-1:0]                cq_free,
  output logic [FP_MAX-1:0]             fp_valid,
  output logic [DW*FP_MAX-1:0]          fp_data,
  output logic [VEC_MAX-1:0]            vec_valid,
  output logic [DW*VEC_MAX-1:0]         vec_data,
  output logic [INT_MAX-1:0]            int_valid,
  output logic [DW*INT_MAX-1:0]         int_data,
  output logic [$clog2(DISP_W+1)-1:0]   cq_alloc
);
  localparam int OCW = $clog2(DEPTH + 1);
  localparam int DCW = $clog2(DISP_W + 1);

  logic [OCW-1:0]         occ;
  logic [2*DISP_W-1:0]    head_cls;
  logic [DW*DISP_W-1:0]   head_data;
  logic [DISP_W-1:0]      go;
  logic [DCW-1:0]         n_disp;

  iqd_buffer #(.DW(DW), .DEPTH(DEPTH), .FETCH_W(FETCH_W), .DISP_W(DISP_W)) u_buf (
    .clk(clk), .rst(rst), .flush(flush),
    .fe_cnt(fe_cnt), .fe_cls(fe_cls), .fe_data(fe_data),
    .n_disp(n_disp), .occ(occ), .head_cls(head_cls), .head_data(head_data)
  );

  iqd_select #(.DEPTH(DEPTH), .DISP_W(DISP_W), .FP_MAX(FP_MAX), .VEC_MAX(VEC_MAX),
               .INT_MAX(INT_MAX), .CRW(CRW), .CQW(CQW)) u_sel (
    .clk(clk), .rst(rst), .flush(flush), .occ(occ), .head_cls(head_cls),
    .fp_credit(fp_credit), .vec_credit(vec_credit), .int_credit(int_credit),
    .cq_free(cq_free), .go(go), .n_disp(n_disp)
  );

  iqd_route #(.DW(DW), .DISP_W(DISP_W), .FP_MAX(FP_MAX), .VEC_MAX(VEC_MAX),
              .INT_MAX(INT_MAX)) u_route (
    .clk(clk), .rst(rst), .go(go), .head_cls(head_cls), .head_data(head_data),
    .n_disp(n_disp),
    .fp_valid(fp_valid), .fp_data(fp_data), .vec_valid(vec_valid), .vec_data(vec_data),
    .int_valid(int_valid), .int_data(int_data), .cq_alloc(cq_alloc)
  );

  assign fe_free = OCW'(DEPTH) - occ;

  // R5: slots taken never exceed the completion credit offered
  p_cq_credit_r5: assert property (@(posedge clk) disable iff (rst)
    int'(cq_alloc) <= int'($past(cq_free)));

  // R4: each port honours its credit
  p_int_credit_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(int_valid) <= int'($past(int_credit)));
  p_vec_credit_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(vec_valid) <= int'($past(vec_credit)));
  p_fp_credit_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(fp_valid) <= int'($past(fp_credit)));

  // R8: a flush cycle dispatches nothing
  p_flush_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> cq_alloc == '0);
endmodule

// File: tb/iq_dispatch_bench.sv
`timescale 1ns/1ps
module iq_dispatch_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic [2:0]  fe_cnt = '0;
  logic [7:0]  fe_cls = '0;
  logic [63:0] fe_data = '0;
  logic [3:0]  fe_free;
  logic [3:0]  fp_credit = '0, vec_credit = '0, int_credit = '0;
  logic [4:0]  cq_free = '0;
  logic [0:0]  fp_valid;
  logic [15:0] fp_data;
  logic [1:0]  vec_valid;
  logic [31:0] vec_data;
  logic [2:0]  int_valid;
  logic [47:0] int_data;
  logic [1:0]  cq_alloc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [1:0]  m_cls [16];
  logic [15:0] m_dat [16];
  int          m_cnt = 0;
  logic [15:0] seq = 16'h0100;
  logic [31:0] rng = 32'h1234_5679;

  always #10 clk = ~clk;

  iq_dispatch u_iq_dispatch (
    .clk(clk), .rst(rst), .flush(flush), .fe_cnt(fe_cnt), .fe_cls(fe_cls),
    .fe_data(fe_data), .fe_free(fe_free), .fp_credit(fp_credit),
    .vec_credit(vec_credit), .int_credit(int_credit), .cq_free(cq_free),
    .fp_valid(fp_valid), .fp_data(fp_data), .vec_valid(vec_valid),
    .vec_data(vec_data), .int_valid(int_valid), .int_data(int_data),
    .cq_alloc(cq_alloc)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic run_cycle(input int fc, input logic [7:0] cl, input logic fl,
                           input int fpc, input int vc, input int ic, input int cq);
    int used, nf, nv, ni, lf, lv, li, acc;
    logic stop, ok;
    logic [0:0]  e_fpv;  logic [15:0] e_fpd;
    logic [1:0]  e_vcv;  logic [31:0] e_vcd;
    logic [2:0]  e_inv;  logic [47:0] e_ind;
    @(negedge clk);
    flush = fl; fe_cnt = 3'(fc); fe_cls = cl;
    for (int j = 0; j < 4; j++) fe_data[16*j +: 16] = seq + 16'(j);
    fp_credit = 4'(fpc); vec_credit = 4'(vc); int_credit = 4'(ic); cq_free = 5'(cq);
    e_fpv = '0; e_fpd = '0; e_vcv = '0; e_vcd = '0; e_inv = '0; e_ind = '0;
    lf = imin(1, fpc); lv = imin(2, vc); li = imin(3, ic);
    used = 0; nf = 0; nv = 0; ni = 0; stop = fl;
    for (int k = 0; k < 3; k++) begin
      ok = 0;
      if (!stop && k < m_cnt && used < cq) begin
        case (m_cls[k])
          2'd1: ok = nf < lf;
          2'd2: ok = nv < lv;
          2'd0: ok = ni < li;
          default: ok = 1;
        endcase
      end
      if (!ok) stop = 1;
      else begin
        case (m_cls[k])
          2'd1: begin e_fpv[nf] = 1; e_fpd[16*nf +: 16] = m_dat[k]; nf++; end
          2'd2: begin e_vcv[nv] = 1; e_vcd[16*nv +: 16] = m_dat[k]; nv++; end
          2'd0: begin e_inv[ni] = 1; e_ind[16*ni +: 16] = m_dat[k]; ni++; end
          default: ;
        endcase
        used++;
      end
    end
    if (fl) m_cnt = 0;
    else begin
      acc = imin(fc, 12 - m_cnt);
      for (int i = 0; i + used < m_cnt; i++) begin
        m_cls[i] = m_cls[i + used]; m_dat[i] = m_dat[i + used];
      end
      m_cnt = m_cnt - used;
      for (int j = 0; j < acc; j++) begin
        m_cls[m_cnt] = cl[2*j +: 2]; m_dat[m_cnt] = seq + 16'(j); m_cnt++;
      end
    end
    seq = seq + 16'd4;
    @(posedge clk); #2;
    chk("R2 free count", 64'(fe_free), 64'(12 - m_cnt));
    chk("R4 fp port", 64'({fp_valid, fp_data}), 64'({e_fpv, e_fpd}));
    chk("R4 vec port", 64'({vec_valid, vec_data}), 64'({e_vcv, e_vcd}));
    chk("R7 int port order", 64'({int_valid, int_data}), 64'({e_inv, e_ind}));
    chk("R5 alloc count", 64'(cq_alloc), 64'(used));
    if (fl) chk("R8 flush empties", 64'(fe_free), 64'd12);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: reset state
    chk("R1 reset free", 64'(fe_free), 64'd12);
    chk("R1 reset valids", 64'({fp_valid, vec_valid, int_valid}), 64'd0);
    chk("R1 reset alloc", 64'(cq_alloc), 64'd0);

    // R3: four integers waiting, only three may leave
    run_cycle(4, 8'h00, 0, 0, 0, 0, 0);
    run_cycle(0, 8'h00, 0, 3, 3, 3, 8);
    chk("R3 three per cycle", 64'(cq_alloc), 64'd3);
    run_cycle(0, 8'h00, 0, 3, 3, 3, 8);
    chk("R3 fourth follows", 64'(int_valid), 64'b001);

    // R6: second FP blocked holds back integer behind it
    run_cycle(4, 8'h05, 0, 0, 0, 0, 0);
    run_cycle(0, 8'h00, 0, 1, 2, 3, 8);
    chk("R6 fp only", 64'(fp_valid), 64'd1);
    chk("R6 younger int held", 64'(int_valid), 64'd0);
    run_cycle(0, 8'h00, 1, 0, 0, 0, 0);

    // R5: none-class needs a completion slot
    run_cycle(2, 8'h03, 0, 0, 0, 0, 0);
    run_cycle(0, 8'h00, 0, 1, 2, 3, 0);
    chk("R5 zero credit blocks none", 64'(cq_alloc), 64'd0);
    run_cycle(0, 8'h00, 0, 1, 2, 3, 1);
    chk("R5 none takes slot", 64'(cq_alloc), 64'd1);
    chk("R5 int waits for slot", 64'(int_valid), 64'd0);
    run_cycle(0, 8'h00, 1, 0, 0, 0, 0);

    // R2: fill to full, excess dropped, collide with dispatch
    for (int i = 0; i < 3; i++) run_cycle(4, 8'h00, 0, 0, 0, 0, 0);
    chk("R2 full", 64'(fe_free), 64'd0);
    run_cycle(4, 8'h00, 0, 0, 0, 0, 0);
    chk("R2 full rejects", 64'(fe_free), 64'd0);
    run_cycle(4, 8'h00, 0, 0, 0, 3, 3);
    chk("R2 room from old occupancy", 64'(fe_free), 64'd3);
    for (int i = 0; i < 5; i++) run_cycle(0, 8'h00, 0, 1, 2, 3, 3);

    // R8: flush with fetch and open credits
    run_cycle(4, 8'h1B, 0, 0, 0, 0, 0);
    run_cycle(4, 8'h00, 1, 1, 2, 3, 8);
    chk("R8 no dispatch", 64'(cq_alloc), 64'd0);

    // Sweep
    for (int t = 0; t < 6000; t++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      run_cycle(int'(rng[2:0]) % 5, rng[10:3], (rng[17:12] == 6'd0),
                int'(rng[19:18]), int'(rng[21:20]), int'(rng[23:22]),
                int'(rng[26:24]) % 5);
    end
    finish_run();
  end
endmodule